// File: doc/BRIEF.md
# Radix-4 Booth Multiply-Accumulate Unit

This block multiplies two signed 8-bit operands and adds the product into a 20-bit two's complement running sum. The multiplier operand `y_in` is recoded into four radix-4 signed digits. Each digit selects the multiplicand as zero, once or twice its value, with a negation when the digit is negative, so the block makes four partial-product rows. A carry-save adder network reduces these rows, plus one row that holds the negation carry-ins, to a sum row and a carry row. One carry-propagate add of those two rows gives the 16-bit product.

A cycle with `in_valid` high adds `x_in * y_in` into the accumulator. `clear` empties the accumulator. When `clear` and `in_valid` are high together, the accumulator is loaded with the new product, which starts a fresh dot product without a lost cycle. `out_valid` marks each cycle in which the registered result reflects a new operand pair.

Top module: `booth_mac`

## Requirements
- R1: With the accumulator empty, one valid pair gives `acc_out` equal to the signed 16-bit product `x_in * y_in`, sign-extended to 20 bits. This holds for every operand pair, including -128 * -128 = 16384 and -128 * 127 = -16256.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: With `in_valid` high and `clear` low, the next `acc_out` is the previous `acc_out` plus the signed product.
- R4: With `clear` high and `in_valid` low, the next `acc_out` is zero.
- R5: With `clear` and `in_valid` both high, the next `acc_out` is the product alone. The earlier sum is discarded.
- R6: With `clear` and `in_valid` both low, `acc_out` keeps its value.
- R7: After reset, `acc_out` is zero and `out_valid` is low.
- R8: The accumulator wraps modulo 2^20 and does not saturate. Adding 16384 to 507904 gives -524288.
- R9: Each 3-bit group {y[2i+1], y[2i], y[2i-1]} of `y_in` is recoded into one digit in {-2,-1,0,+1,+2}, with y[-1] taken as 0. The recoder selects at most one of the magnitudes 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operand pair is present this cycle |
| clear | input | 1 | Synchronous empty of the accumulator |
| x_in | input | 8 | Signed multiplicand |
| y_in | input | 8 | Signed multiplier, Booth-recoded |
| acc_out | output | 20 | Registered two's complement running sum |
| out_valid | output | 1 | `acc_out` includes a new product |

## Verification
The assertions rely on `clear`, `in_valid` and both operands being clean, defined levels that are sampled at each rising edge, and on reset being released before any operand is applied. The bench changes every input only on the falling clock edge and holds it for a full cycle. It keeps reset high for the whole operand sequence, so each past-value comparison refers to a cycle that the design actually registered. The operand corners come first: both extreme negatives, mixed signs, zero and all-ones multipliers. After these come long accumulation runs that cross the 20-bit wrap point.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

    // Selection produced by one radix-4 digit
    typedef struct packed {
        logic neg;   // digit is negative
        logic one;   // magnitude 1
        logic two;   // magnitude 2
    } booth_sel_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_mac_pkg::*;
#(
    parameter int YW = 8
) (
    input  logic [YW-1:0]              y,
    output booth_sel_t [YW/2-1:0]      sel
);
    localparam int ND = YW / 2;

    for (genvar i = 0; i < ND; i++) begin : g_digit
        logic [2:0] grp;
        if (i == 0) begin : g_low
            assign grp = {y[1], y[0], 1'b0};
        end else begin : g_mid
            assign grp = {y[2*i+1], y[2*i], y[2*i-1]};
        end

        always_comb begin
            sel[i].one = grp[1] ^ grp[0];
            sel[i].two = (grp == 3'b011) || (grp == 3'b100);
            sel[i].neg = grp[2] & ~(grp[1] & grp[0]);
        end

        always_comb begin
            p_sel_onehot_r9: assert ($onehot0({sel[i].one, sel[i].two}) || $isunknown(grp));
        end
    end

endmodule

// File: rtl/booth_pp_rows.sv
module booth_pp_rows
    import booth_mac_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 8,
    parameter int PW = XW + YW
) (
    input  logic [XW-1:0]                   x,
    input  booth_sel_t [YW/2-1:0]           sel,
    output logic [YW/2:0][PW-1:0]           rows
);
    localparam int ND = YW / 2;
    localparam int MW = XW + 1;

    for (genvar i = 0; i < ND; i++) begin : g_row
        logic [MW-1:0] mag;
        logic [MW-1:0] flip;
        logic [PW-1:0] ext;
        always_comb begin
            if (sel[i].one)      mag = {x[XW-1], x};
            else if (sel[i].two) mag = {x, 1'b0};
            else                 mag = '0;
            flip = mag ^ {MW{sel[i].neg}};
            ext  = {{(PW-MW){flip[MW-1]}}, flip};
            rows[i] = ext << (2 * i);
        end
    end

    // Row of +1 carry-ins that completes each negation
    always_comb begin
        rows[ND] = '0;
        for (int i = 0; i < ND; i++) begin
            rows[ND][2*i] = sel[i].neg;
        end
    end

endmodule

// File: rtl/csa_reduce.sv
module csa_reduce #(
    parameter int NR = 5,
    parameter int W  = 16
) (
    input  logic [NR-1:0][W-1:0] rows,
    output logic [W-1:0]         sum_row,
    output logic [W-1:0]         carry_row
);
    localparam int NS = NR - 2;

    logic [NS-1:0][W-1:0] st_s;
    logic [NS-1:0][W-1:0] st_c;

    for (genvar k = 0; k < NS; k++) begin : g_stage
        logic [W-1:0] a, b, c;
        if (k == 0) begin : g_first
            assign a = rows[0];
            assign b = rows[1];
        end else begin : g_next
            assign a = st_s[k-1];
            assign b = st_c[k-1];
        end
        assign c = rows[k+2];
        assign st_s[k] = a ^ b ^ c;
        assign st_c[k] = ((a & b) | (a & c) | (b & c)) << 1;
    end

    assign sum_row   = st_s[NS-1];
    assign carry_row = st_c[NS-1];

endmodule

// File: rtl/booth_mac.sv
module booth_mac
    import booth_mac_pkg::*;
#(
    parameter int XW    = 8,
    parameter int YW    = 8,
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             clear,
    input  logic [XW-1:0]    x_in,
    input  logic [YW-1:0]    y_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             out_valid
);
    localparam int ND = YW / 2;
    localparam int NR = ND + 1;
    localparam int PW = XW + YW;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             vld;
    } mac_state_t;

    booth_sel_t [ND-1:0]     sel;
    logic [NR-1:0][PW-1:0]   rows;
    logic [PW-1:0]           sum_row, carry_row, prod;
    logic [ACC_W-1:0]        prod_ext;
    mac_state_t              st_d, st_q;

    booth_recoder #(.YW(YW)) u_rec (
        .y   (y_in),
        .sel (sel)
    );

    booth_pp_rows #(.XW(XW), .YW(YW), .PW(PW)) u_pp (
        .x    (x_in),
        .sel  (sel),
        .rows (rows)
    );

    csa_reduce #(.NR(NR), .W(PW)) u_csa (
        .rows      (rows),
        .sum_row   (sum_row),
        .carry_row (carry_row)
    );

    always_comb begin
        prod     = sum_row + carry_row;
        prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
        st_d     = st_q;
        st_d.vld = in_valid;
        if (clear)    st_d.acc = '0;
        if (in_valid) st_d.acc = st_d.acc + prod_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out   = st_q.acc;
    assign out_valid = st_q.vld;

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_accum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clear) |=> acc_out == $past(acc_out) + $past(prod_ext));
    p_clear_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !in_valid) |=> acc_out == '0);
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && in_valid) |=> acc_out == $past(prod_ext));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !in_valid) |=> $stable(acc_out));

endmodule

// File: tb/tb_booth_mac.sv
module tb_booth_mac;
    localparam int XW = 8, YW = 8, ACC_W = 20;

    logic clk = 0, rst_n = 0, in_valid = 0, clear = 0;
    logic [XW-1:0] x_in = '0;
    logic [YW-1:0] y_in = '0;
    logic [ACC_W-1:0] acc_out;
    logic out_valid;

    int n_checks = 0, n_errors = 0;
    logic signed [ACC_W-1:0] model = '0;
    bit done = 0;

    typedef struct {
        logic             vld;
        logic [ACC_W-1:0] acc;
        string            tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    booth_mac #(.XW(XW), .YW(YW), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear),
        .x_in(x_in), .y_in(y_in), .acc_out(acc_out), .out_valid(out_valid)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic issue(int x, int y, bit clr, bit vld, string tag);
        exp_t e;
        logic signed [31:0] p;
        @(negedge clk);
        x_in = x[XW-1:0]; y_in = y[YW-1:0]; clear = clr; in_valid = vld;
        p = $signed(x_in) * $signed(y_in);
        if (clr) model = '0;
        if (vld) model = model + p[ACC_W-1:0];
        e.vld = vld; e.acc = model; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R2 out_valid"}, 32'(out_valid), 32'(e.vld));
                check({e.tag, " acc_out"}, 32'(acc_out), 32'(e.acc));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset acc_out", 32'(acc_out), 32'd0);
        check("R7 reset out_valid", 32'(out_valid), 32'd0);
        rst_n = 1;

        // Single products from an empty accumulator
        issue(-128, -128, 1, 1, "R1 -128*-128");
        issue(-128,  127, 1, 1, "R1 -128*127");
        issue( 127,  127, 1, 1, "R1 127*127");
        issue( 127, -128, 1, 1, "R1 127*-128");
        issue(  85,  -86, 1, 1, "R1 alt bits");
        issue( -37,   -1, 1, 1, "R9 y all ones");
        issue(  99,    0, 1, 1, "R9 y zero");
        issue(  -1,   85, 1, 1, "R9 y 0x55");
        issue(  53,  -86, 1, 1, "R9 y 0xaa");
        for (int i = 0; i < 24; i++)
            issue($urandom_range(255), $urandom_range(255), 1, 1, "R1 random");

        // Running accumulation
        issue(0, 0, 1, 0, "R4 clear");
        for (int i = 0; i < 30; i++)
            issue($urandom_range(255), $urandom_range(255), 0, 1, "R3 accumulate");
        for (int i = 0; i < 4; i++)
            issue(i, i, 0, 0, "R6 hold");
        issue(0, 0, 1, 0, "R4 clear nonzero");
        issue(0, 0, 0, 0, "R6 hold zero");
        issue(12, -7, 0, 1, "R3 after clear");
        issue(-100, 90, 1, 1, "R5 clear with valid");
        issue(5, 5, 0, 1, "R3 after load");

        // Wrap past the 20-bit range
        issue(0, 0, 1, 0, "R4 clear before wrap");
        for (int i = 0; i < 40; i++)
            issue(-128, -128, 0, 1, "R8 wrap");
        for (int i = 0; i < 40; i++)
            issue(-128, 127, 0, 1, "R8 wrap down");
        issue(0, 0, 0, 0, "R6 idle end");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule